// File: doc/BRIEF.md
# External Bus Word Packer

The packer sits between an internal word stream and an external bus that is 64 bits wide. On that bus every address selects one 32-bit location. The low 32-bit lane serves even addresses and the high lane serves odd addresses, so one transfer can reach an even location and the odd one after it. Internal words are 16, 32, 48 or 64 bits wide. In the write direction the packer accepts these words on a valid/ready stream and produces bus beats. Each beat carries a word address, the data and four halfword enables. In the read direction it issues read beats and rebuilds internal words from the returned data.

A stream begins with a configuration load. The load captures the direction, the word size and a start word address that may be odd. The packer works in 16-bit halfword units. Two 16-bit words share one location, and the first of them sits in the low half. A 48-bit word always covers two locations, and the top halfword of that span is a zero pad. Words of 48 or 64 bits that start on an odd location split across two beats, and the remainder is carried into the next beat. In the write direction the last-word marker flushes any partly filled pair.

Top module: `ext_word_packer`

## Requirements
- R1: Synchronous reset clears all state. After reset, `ext_valid`, `out_valid` and `in_ready` are 0 until a configuration load. A load (`cfg_load`=1) discards any partly packed or buffered halfwords, and stream positions restart at `cfg_addr`.
- R2: `ext_be` bit i enables data bits 16i+15:16i. Bits 1:0 form the low lane, which holds the even location 2p. Bits 3:2 form the high lane, which holds the odd location 2p+1. `ext_addr` is 2p when any low-lane enable is set, and 2p+1 when only high-lane enables are set.
- R3: With `cfg_mode`=1 (32-bit), word k is written to location A+k, where A is the start address.
- R4: With `cfg_mode`=3 (64-bit), bits 31:0 of a word go to its first location and bits 63:32 go to the following location.
- R5: With `cfg_mode`=2 (48-bit), each word covers two locations. Bits 31:0 go to the first location and bits 47:32 go to bits 15:0 of the second. Bits 31:16 of the second location are written as zero with their enables set.
- R6: With `cfg_mode`=0 (16-bit), each word fills one halfword at consecutive halfword positions, starting at bits 15:0 of location A. A trailing single halfword is sent with only its own enable bit set.
- R7: When the start address is odd, the first beat has `ext_be[1:0]`=0. The beat after it starts in the low lane.
- R8: With `cfg_rd`=1, read beats have `ext_we`=0 and `ext_be[3]`=1. Words are rebuilt with the same mapping as R3 to R6. `out_data` is zero above the word width, and for 48-bit words the pad halfword is discarded.
- R9: Under backpressure on either side, no data is lost or duplicated. A stalled beat keeps its address, enables and data, and a stalled output word keeps its value.
- R10: When `in_last`=1 on an accepted word, every halfword still pending is sent. A split word at the end takes one extra beat.
- Bits of `in_data` above the selected word width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Start a new stream with the settings below |
| cfg_rd | input | 1 | 1 = read direction, 0 = write direction |
| cfg_mode | input | 2 | Word size: 0=16, 1=32, 2=48, 3=64 bits |
| cfg_addr | input | ADDR_W | Start word address |
| in_valid | input | 1 | Write word valid |
| in_ready | output | 1 | Write word accepted |
| in_data | input | 4*HALF_W | Write word, right-aligned |
| in_last | input | 1 | Final word of the write stream |
| out_valid | output | 1 | Read word valid |
| out_ready | input | 1 | Read word taken |
| out_data | output | 4*HALF_W | Rebuilt read word, zero-extended |
| ext_valid | output | 1 | Bus beat valid |
| ext_ready | input | 1 | Bus beat accepted |
| ext_we | output | 1 | 1 = write beat, 0 = read beat |
| ext_addr | output | ADDR_W | Word address of the beat |
| ext_be | output | 4 | Halfword enables |
| ext_wdata | output | 4*HALF_W | Write data |
| ext_rdata | input | 4*HALF_W | Read data, valid in the accepting cycle |

## Verification
In the write path, the beat that completes a pair and the carry of a split word's remainder fall in the same cycle. This happens for 48-bit and 64-bit words at odd start addresses. A pending final flush can also land on a stalled bus. In the read path, popping a finished word and merging a returning beat occur in one cycle whenever both sides are ready. The bench provokes both cases by stepping through every word size from even and odd start addresses with toggling ready patterns on each side. It checks every strobed halfword against a halfword-address model, and every rebuilt word against a model of the memory.

// File: rtl/xbp_pkg.sv
package xbp_pkg;

   typedef enum logic [1:0] {
      WS_16 = 2'd0,
      WS_32 = 2'd1,
      WS_48 = 2'd2,
      WS_64 = 2'd3
   } wsize_e;

   // halfword positions a word occupies on the bus, pad included
   function automatic logic [2:0] span_halves(wsize_e m);
      case (m)
         WS_16:   span_halves = 3'd1;
         WS_32:   span_halves = 3'd2;
         default: span_halves = 3'd4;
      endcase
   endfunction

   // halfwords that carry word data
   function automatic logic [3:0] data_halves(wsize_e m);
      case (m)
         WS_16:   data_halves = 4'b0001;
         WS_32:   data_halves = 4'b0011;
         WS_48:   data_halves = 4'b0111;
         default: data_halves = 4'b1111;
      endcase
   endfunction

   // halfword enables a word raises, pad included
   function automatic logic [3:0] strobe_halves(wsize_e m);
      case (m)
         WS_16:   strobe_halves = 4'b0001;
         WS_32:   strobe_halves = 4'b0011;
         default: strobe_halves = 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/xbp_wr.sv
module xbp_wr
   import xbp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int HALF_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic [ADDR_W-1:0]   start_addr,
   input  wsize_e              mode,
   input  logic                active,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [4*HALF_W-1:0] in_data,
   input  logic                in_last,
   output logic                b_valid,
   input  logic                b_ready,
   output logic [ADDR_W-1:0]   b_addr,
   output logic [3:0]          b_be,
   output logic [4*HALF_W-1:0] b_data
);
   localparam int BUS_W  = 4 * HALF_W;
   localparam int WIN_W  = 2 * BUS_W;
   localparam int PAIR_W = ADDR_W - 1;

   logic [BUS_W-1:0]  pb;        // partly filled pair
   logic [3:0]        pm;        // its halfword enables
   logic [1:0]        hpos;      // next free halfword in the pair
   logic [PAIR_W-1:0] pair;
   logic              flush_pend;

   logic [3:0]       dmask, smask;
   logic [2:0]       span, total;
   logic [BUS_W-1:0] word_clean;
   logic [WIN_W-1:0] win;
   logic [7:0]       wmsk;
   logic             advance, take;

   assign dmask = data_halves(mode);
   assign smask = strobe_halves(mode);
   assign span  = span_halves(mode);

   for (genvar i = 0; i < 4; i++) begin : g_clean
      assign word_clean[i*HALF_W +: HALF_W] =
         dmask[i] ? in_data[i*HALF_W +: HALF_W] : {HALF_W{1'b0}};
   end

   assign win   = {{BUS_W{1'b0}}, pb} | ({{BUS_W{1'b0}}, word_clean} << (HALF_W * hpos));
   assign wmsk  = {4'b0000, pm} | ({4'b0000, smask} << hpos);
   assign total = {1'b0, hpos} + span;

   assign advance  = !b_valid || b_ready;
   assign in_ready = active && !flush_pend && advance;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         b_valid    <= 1'b0;
         b_addr     <= '0;
         b_be       <= '0;
         b_data     <= '0;
         pb         <= '0;
         pm         <= '0;
         hpos       <= '0;
         pair       <= '0;
         flush_pend <= 1'b0;
      end else if (load) begin
         b_valid    <= 1'b0;
         pb         <= '0;
         pm         <= '0;
         hpos       <= {start_addr[0], 1'b0};
         pair       <= start_addr[ADDR_W-1:1];
         flush_pend <= 1'b0;
      end else begin
         if (advance) b_valid <= 1'b0;
         if (take) begin
            if (total >= 3'd4) begin
               b_valid <= 1'b1;
               b_data  <= win[BUS_W-1:0];
               b_be    <= wmsk[3:0];
               b_addr  <= {pair, !(wmsk[0] | wmsk[1])};
               pair    <= pair + 1'b1;
               pb      <= win[WIN_W-1:BUS_W];
               pm      <= wmsk[7:4];
               hpos    <= total[1:0];
               if (in_last && total != 3'd4) flush_pend <= 1'b1;
            end else if (in_last) begin
               b_valid <= 1'b1;
               b_data  <= win[BUS_W-1:0];
               b_be    <= wmsk[3:0];
               b_addr  <= {pair, !(wmsk[0] | wmsk[1])};
               pair    <= pair + 1'b1;
               pb      <= '0;
               pm      <= '0;
               hpos    <= '0;
            end else begin
               pb   <= win[BUS_W-1:0];
               pm   <= wmsk[3:0];
               hpos <= total[1:0];
            end
         end else if (flush_pend && advance) begin
            b_valid    <= 1'b1;
            b_data     <= pb;
            b_be       <= pm;
            b_addr     <= {pair, !(pm[0] | pm[1])};
            pair       <= pair + 1'b1;
            pb         <= '0;
            pm         <= '0;
            hpos       <= '0;
            flush_pend <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/xbp_rd.sv
module xbp_rd
   import xbp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int HALF_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic [ADDR_W-1:0]   start_addr,
   input  wsize_e              mode,
   input  logic                active,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [4*HALF_W-1:0] out_data,
   output logic                r_req,
   input  logic                r_ready,
   output logic [ADDR_W-1:0]   r_addr,
   output logic [3:0]          r_be,
   input  logic [4*HALF_W-1:0] r_data
);
   localparam int BUS_W  = 4 * HALF_W;
   localparam int WIN_W  = 2 * BUS_W;
   localparam int PAIR_W = ADDR_W - 1;

   logic [WIN_W-1:0]  rbuf;      // gathered halfwords, oldest lowest
   logic [3:0]        rcnt;
   logic [1:0]        hpos;
   logic [PAIR_W-1:0] pair;

   logic [3:0]       dmask, base, rcnt_n;
   logic [2:0]       span, nget;
   logic             got, pop;
   logic [WIN_W-1:0] shifted, incoming, rbuf_n;

   assign dmask = data_halves(mode);
   assign span  = span_halves(mode);

   assign r_req  = active && (rcnt <= 4'd4);
   assign r_be   = 4'b1111 << hpos;
   assign r_addr = {pair, hpos[1]};
   assign got    = r_req && r_ready;
   assign nget   = 3'd4 - {1'b0, hpos};

   assign out_valid = active && (rcnt >= {1'b0, span});
   assign pop       = out_valid && out_ready;

   for (genvar i = 0; i < 4; i++) begin : g_out
      assign out_data[i*HALF_W +: HALF_W] =
         dmask[i] ? rbuf[i*HALF_W +: HALF_W] : {HALF_W{1'b0}};
   end

   assign base     = rcnt - (pop ? {1'b0, span} : 4'd0);
   assign shifted  = pop ? (rbuf >> (HALF_W * span)) : rbuf;
   assign incoming = {{BUS_W{1'b0}}, r_data} >> (HALF_W * hpos);
   assign rbuf_n   = got ? (shifted | (incoming << (HALF_W * base))) : shifted;
   assign rcnt_n   = base + (got ? {1'b0, nget} : 4'd0);

   always_ff @(posedge clk) begin
      if (rst) begin
         rbuf <= '0;
         rcnt <= '0;
         hpos <= '0;
         pair <= '0;
      end else if (load) begin
         rbuf <= '0;
         rcnt <= '0;
         hpos <= {start_addr[0], 1'b0};
         pair <= start_addr[ADDR_W-1:1];
      end else begin
         rbuf <= rbuf_n;
         rcnt <= rcnt_n;
         if (got) begin
            hpos <= '0;
            pair <= pair + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ext_word_packer.sv
module ext_word_packer
   import xbp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int HALF_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_load,
   input  logic                cfg_rd,
   input  logic [1:0]          cfg_mode,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [4*HALF_W-1:0] in_data,
   input  logic                in_last,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [4*HALF_W-1:0] out_data,
   output logic                ext_valid,
   input  logic                ext_ready,
   output logic                ext_we,
   output logic [ADDR_W-1:0]   ext_addr,
   output logic [3:0]          ext_be,
   output logic [4*HALF_W-1:0] ext_wdata,
   input  logic [4*HALF_W-1:0] ext_rdata
);
   localparam int BUS_W = 4 * HALF_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ext_word_packer: ADDR_W must be at least 2");
   end
   if (HALF_W < 1) begin : g_bad_half
      $error("ext_word_packer: HALF_W must be positive");
   end

   wsize_e mode_q;
   logic   rd_q, act_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= WS_16;
         rd_q   <= 1'b0;
         act_q  <= 1'b0;
      end else if (cfg_load) begin
         mode_q <= wsize_e'(cfg_mode);
         rd_q   <= cfg_rd;
         act_q  <= 1'b1;
      end
   end

   logic              b_valid, r_req;
   logic [ADDR_W-1:0] b_addr, r_addr;
   logic [3:0]        b_be, r_be;
   logic [BUS_W-1:0]  b_data;

   xbp_wr #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_wr (
      .clk        (clk),
      .rst        (rst),
      .load       (cfg_load),
      .start_addr (cfg_addr),
      .mode       (mode_q),
      .active     (act_q && !rd_q),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .in_last    (in_last),
      .b_valid    (b_valid),
      .b_ready    (ext_ready && !rd_q),
      .b_addr     (b_addr),
      .b_be       (b_be),
      .b_data     (b_data)
   );

   xbp_rd #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_rd (
      .clk        (clk),
      .rst        (rst),
      .load       (cfg_load),
      .start_addr (cfg_addr),
      .mode       (mode_q),
      .active     (act_q && rd_q),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .r_req      (r_req),
      .r_ready    (ext_ready && rd_q),
      .r_addr     (r_addr),
      .r_be       (r_be),
      .r_data     (ext_rdata)
   );

   assign ext_we    = !rd_q;
   assign ext_valid = rd_q ? r_req  : b_valid;
   assign ext_addr  = rd_q ? r_addr : b_addr;
   assign ext_be    = rd_q ? r_be   : b_be;
   assign ext_wdata = b_data;

endmodule

// File: rtl/xbp_chk.sv
module xbp_chk #(
   parameter int ADDR_W = 32,
   parameter int HALF_W = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                cfg_load,
   input logic                in_ready,
   input logic                out_valid,
   input logic                out_ready,
   input logic [4*HALF_W-1:0] out_data,
   input logic                ext_valid,
   input logic                ext_ready,
   input logic                ext_we,
   input logic [ADDR_W-1:0]   ext_addr,
   input logic [3:0]          ext_be,
   input logic [4*HALF_W-1:0] ext_wdata
);

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (!ext_valid && !out_valid && !in_ready));

   p_addr_parity_r2: assert property (@(posedge clk) disable iff (rst)
      ext_valid |-> (ext_addr[0] == !(ext_be[0] | ext_be[1])));

   p_read_top_lane_r8: assert property (@(posedge clk) disable iff (rst)
      (ext_valid && !ext_we) |-> ext_be[3]);

   p_beat_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (ext_valid && !ext_ready && ext_we && !cfg_load) |=>
         (ext_valid && $stable(ext_addr) && $stable(ext_be) && $stable(ext_wdata)));

   p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready && !cfg_load) |=> (out_valid && $stable(out_data)));

endmodule

bind ext_word_packer xbp_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cfg_load  (cfg_load),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .ext_valid (ext_valid),
   .ext_ready (ext_ready),
   .ext_we    (ext_we),
   .ext_addr  (ext_addr),
   .ext_be    (ext_be),
   .ext_wdata (ext_wdata)
);

// File: tb/sim_ext_word_packer.sv
module sim_ext_word_packer;

   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_load, cfg_rd;
   logic [1:0]  cfg_mode;
   logic [31:0] cfg_addr;
   logic        in_valid, in_ready, in_last;
   logic [63:0] in_data;
   logic        out_valid, out_ready;
   logic [63:0] out_data;
   logic        ext_valid, ext_ready, ext_we;
   logic [31:0] ext_addr;
   logic [3:0]  ext_be;
   logic [63:0] ext_wdata, ext_rdata;

   int nchk = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   ext_word_packer u0 (
      .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_rd(cfg_rd),
      .cfg_mode(cfg_mode), .cfg_addr(cfg_addr),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_we(ext_we),
      .ext_addr(ext_addr), .ext_be(ext_be), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
   );

   // memory model: value of each halfword address
   function automatic logic [15:0] memv(logic [32:0] h);
      return (h[15:0] * 16'h0F1B) ^ h[31:16] ^ 16'hA5C3;
   endfunction

   always_comb begin
      for (int i = 0; i < 4; i++)
         ext_rdata[i*16 +: 16] = memv({ext_addr[31:1], 2'b00} + 33'(i));
   end

   function automatic logic [63:0] wword(int k);
      logic [15:0] k16;
      k16 = 16'(k);
      return {16'hF00D ^ k16, 16'hC0DE + k16, 16'h5A00 | k16, 16'h0100 + k16 * 16'd3};
   endfunction

   function automatic bit pat(int bp, int c);
      case (bp)
         0:       return 1'b1;
         1:       return (c % 3) != 1;
         2:       return (c % 2) == 0;
         default: return (c % 4) == 0;
      endcase
   endfunction

   function automatic int span_of(logic [1:0] m);
      return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_load(bit rd, logic [1:0] m, logic [31:0] a);
      @(negedge clk);
      cfg_load = 1'b1; cfg_rd = rd; cfg_mode = m; cfg_addr = a;
      in_valid = 1'b0; out_ready = 1'b0; ext_ready = 1'b0;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic check_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(!ext_valid, "R1 ext_valid after reset", 64'(ext_valid), 64'd0);
      check(!in_ready,  "R1 in_ready after reset",  64'(in_ready),  64'd0);
      check(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      check(!ext_valid && !in_ready && !out_valid, "R1 idle before load", 64'(ext_valid), 64'd0);
   endtask

   // write scenario: halfword-level model, each strobed halfword checked
   task automatic run_wr(logic [1:0] m, logic [31:0] a, int nw, int bp,
                         bit last_en, bit drain, string tag);
      logic [32:0] qa[$];
      logic [15:0] qv[$];
      logic [32:0] h;
      logic [63:0] d;
      int idx, guard, nbeats, extra;
      h = {a, 1'b0};
      for (int k = 0; k < nw; k++) begin
         d = wword(k);
         for (int i = 0; i < span_of(m); i++) begin
            qa.push_back(h + 33'(i));
            qv.push_back((m == 2'd2 && i == 3) ? 16'h0000 : d[i*16 +: 16]);
         end
         h = h + 33'(span_of(m));
      end
      do_load(1'b0, m, a);
      idx = 0; guard = 0; nbeats = 0;
      while ((idx < nw || (drain && qa.size() != 0)) && guard < 600) begin
         @(negedge clk);
         guard++;
         in_valid  = (idx < nw);
         in_data   = wword(idx);
         in_last   = last_en && (idx == nw - 1);
         ext_ready = pat(bp, guard);
         #5;
         if (in_valid && in_ready) idx++;
         if (ext_valid && ext_ready) begin
            check(ext_we && (ext_addr[0] == !(ext_be[0] | ext_be[1])),
                  "R2 address parity vs lanes", {ext_we, ext_be, ext_addr}, 64'd0);
            if (nbeats == 0 && a[0])
               check(ext_be[1:0] == 2'b00, "R7 odd start first beat upper lane only",
                     64'(ext_be), 64'hC);
            if (nbeats == 1 && a[0])
               check(ext_be[0], "R7 second beat resumes at low lane", 64'(ext_be), 64'h1);
            for (int i = 0; i < 4; i++) begin
               if (ext_be[i]) begin
                  if (qa.size() == 0) begin
                     check(1'b0, "R9 duplicated halfword", ext_wdata, 64'd0);
                  end else begin
                     check(({ext_addr[31:1], 2'(i)} == qa[0]) &&
                           (ext_wdata[i*16 +: 16] == qv[0]),
                           $sformatf("%s R2 halfword lane %0d", tag, i),
                           {15'd0, ext_addr[31:1], 2'(i), ext_wdata[i*16 +: 16]},
                           {15'd0, qa[0], qv[0]});
                     void'(qa.pop_front());
                     void'(qv.pop_front());
                  end
               end
            end
            nbeats++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      check(idx == nw, {tag, " all words accepted"}, 64'(idx), 64'(nw));
      if (drain)
         check(qa.size() == 0, "R10 all halfwords sent after last", 64'(qa.size()), 64'd0);
      extra = 0;
      for (int c = 0; c < 4; c++) begin
         ext_ready = 1'b1;
         #5;
         if (ext_valid) extra++;
         @(negedge clk);
      end
      check(extra == 0, "R9 no extra beats", 64'(extra), 64'd0);
      ext_ready = 1'b0;
   endtask

   function automatic logic [63:0] rd_exp(logic [1:0] m, logic [31:0] a, int k);
      logic [63:0] e;
      logic [32:0] hs;
      int nh;
      e  = '0;
      hs = {a, 1'b0} + 33'(k * span_of(m));
      nh = (m == 2'd2) ? 3 : span_of(m);
      for (int i = 0; i < nh; i++) e[i*16 +: 16] = memv(hs + 33'(i));
      return e;
   endfunction

   task automatic run_rd(logic [1:0] m, logic [31:0] a, int nw, int bpe, int bpo, string tag);
      int k, guard;
      bit stall_prev;
      logic [63:0] held;
      do_load(1'b1, m, a);
      k = 0; guard = 0; stall_prev = 1'b0; held = '0;
      while (k < nw && guard < 600) begin
         @(negedge clk);
         guard++;
         ext_ready = pat(bpe, guard);
         out_ready = pat(bpo, guard + 1);
         #5;
         if (stall_prev)
            check(out_valid && out_data == held, "R9 stalled word held", out_data, held);
         if (ext_valid && ext_ready)
            check(!ext_we && ext_be[3] && (ext_addr[0] == !(ext_be[0] | ext_be[1])),
                  "R8 read beat lanes", {ext_we, ext_be, ext_addr}, 64'd0);
         if (out_valid && out_ready) begin
            check(out_data == rd_exp(m, a, k), {tag, " rebuilt word"}, out_data, rd_exp(m, a, k));
            k++;
         end
         stall_prev = out_valid && !out_ready;
         held = out_data;
      end
      check(k == nw, {tag, " read word count"}, 64'(k), 64'(nw));
      @(negedge clk);
      ext_ready = 1'b0; out_ready = 1'b0;
   endtask

   initial begin
      #(20 * 190000);
      nfail++;
      $display("FAIL watchdog expired (R9 progress)");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      cfg_load = 0; cfg_rd = 0; cfg_mode = 0; cfg_addr = 0;
      in_valid = 0; in_data = 0; in_last = 0; out_ready = 0; ext_ready = 0;
      check_reset();
      run_wr(2'd1, 32'h10, 6, 0, 1'b1, 1'b1, "R3");
      run_wr(2'd1, 32'h21, 5, 1, 1'b1, 1'b1, "R3");
      run_wr(2'd3, 32'h30, 4, 0, 1'b1, 1'b1, "R4");
      run_wr(2'd3, 32'h33, 3, 2, 1'b1, 1'b1, "R10");
      run_wr(2'd2, 32'h50, 3, 0, 1'b1, 1'b1, "R5");
      run_wr(2'd2, 32'h55, 4, 1, 1'b1, 1'b1, "R5");
      run_wr(2'd0, 32'h60, 5, 0, 1'b1, 1'b1, "R6");
      run_wr(2'd0, 32'h63, 6, 3, 1'b1, 1'b1, "R6");
      run_wr(2'd0, 32'h40, 1, 0, 1'b0, 1'b0, "R1");
      run_wr(2'd0, 32'h40, 3, 1, 1'b1, 1'b1, "R1");
      run_rd(2'd0, 32'h80, 7, 0, 0, "R8");
      run_rd(2'd0, 32'h81, 5, 1, 2, "R8");
      run_rd(2'd1, 32'h90, 5, 2, 1, "R8");
      run_rd(2'd1, 32'h91, 5, 0, 3, "R9");
      run_rd(2'd2, 32'hA0, 4, 1, 0, "R8");
      run_rd(2'd2, 32'hA3, 4, 3, 1, "R8");
      run_rd(2'd3, 32'hB0, 4, 0, 2, "R8");
      run_rd(2'd3, 32'hB5, 4, 2, 3, "R9");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule